// File: doc/BRIEF.md
# Programmable-Level Channel Grant Arbiter

This block chooses which one of seven transfer channels may use a shared transfer engine. Each channel has a request line, an enable bit and a two-bit priority level that software programs. Only a channel whose request line and enable bit are both high can compete. The arbiter first selects the highest level that has at least one such channel. It then picks the lowest-numbered channel at that level. A single request from a second, lower-ranked controller competes as well. That request wins only when no local channel is competing.

A grant is a registered one-hot vector and it stays asserted until the granted transfer pulses `done`. Requests, enables and levels seen while a grant is held do not affect that grant, so a transfer is never pre-empted. After the release, the next arbitration happens on the following clock edge. All pins are plain control levels with no data path and no valid/ready stage.

Top module: `dma_chan_arbiter`

## Requirements
- R1: At every clock edge after reset, the vector {ext_grant, grant} has at most one bit set.
- R2: When no grant is held and local channels compete, the grant goes to a channel at the numerically highest level. Level 2'd3 is the most urgent and 2'd0 the least. The level of channel i is `lvl[2*i+1:2*i]`.
- R3: Among competing channels at the same level, the lowest channel index receives the grant.
- R4: `ext_grant` is set only when `ext_req` is high and no local channel has both its `req` and `ch_en` bits set at the arbitration edge.
- R5: While a grant is held and `done` is low, `grant` and `ext_grant` do not change. This holds whatever `req`, `ch_en`, `lvl` and `ext_req` do.
- R6: A clock edge at which a grant is held and `done` is high clears all grant outputs. The next arbitration happens at the following edge.
- R7: A channel with `ch_en[i]` low is never granted, even when `req[i]` is high.
- R8: Levels are sampled only at arbitration. A level change while a grant is held leaves that grant alone and decides the next arbitration.
- R9: A `done` pulse while no grant is held has no effect.
- R10: While `rst_n` is low and after it rises, `grant` and `ext_grant` read zero until an arbitration occurs.
- R11: A grant appears on the first clock edge at which an eligible request is seen with no grant held. It is a registered output and is never combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, sampled synchronously |
| req | input | 7 | Per-channel request lines |
| ch_en | input | 7 | Per-channel enable bits |
| lvl | input | 14 | Two-bit priority level for each channel; channel i uses bits 2i+1:2i |
| ext_req | input | 1 | Request from the lower-ranked second controller |
| done | input | 1 | Pulse from the granted transfer that releases the grant |
| grant | output | 7 | One-hot local grant, or zero |
| ext_grant | output | 1 | Grant to the second controller |

## Verification
The bench sweeps all 128 request patterns under eight computed level and enable maps, with the second controller's request varied, and compares each grant against an arithmetic model. A design that inverted the level order or broke ties toward the highest index would grant the wrong channel, and one that ignored `ch_en` would grant a masked channel. Directed cases raise more urgent requests and change levels while a grant is held; a pre-empting design would switch its grant there. Other cases pulse `done` while no grant is held, which a design with a loose release would mis-handle, and check that the second controller wins only when the local side is quiet.

// File: rtl/dca_pkg.sv
package dca_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } arb_state_e;
endpackage

// File: rtl/dca_level_sort.sv
// Reduces the eligible set to the channels sitting at the most urgent
// occupied level.
module dca_level_sort #(
  parameter int unsigned NUM_CH = 7,
  parameter int unsigned LVL_W  = 2
) (
  input  logic [NUM_CH-1:0]       eligible,
  input  logic [NUM_CH*LVL_W-1:0] lvl_flat,
  output logic [NUM_CH-1:0]       top_mask
);
  localparam int unsigned NLVL = 1 << LVL_W;

  logic [NLVL-1:0][NUM_CH-1:0] lvl_mask;

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign lvl_mask[l][c] = eligible[c] &&
                              (lvl_flat[c*LVL_W +: LVL_W] == LVL_W'(l));
    end
  end

  always_comb begin
    logic found;
    found    = 1'b0;
    top_mask = '0;
    for (int l = NLVL - 1; l >= 0; l--) begin
      if (!found && (|lvl_mask[l])) begin
        top_mask = lvl_mask[l];
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dca_first_pick.sv
// Isolates the lowest set bit of a vector.
module dca_first_pick #(
  parameter int unsigned N = 7
) (
  input  logic [N-1:0] vec,
  output logic [N-1:0] onehot
);
  assign onehot = vec & (~vec + N'(1));
endmodule

// File: rtl/dca_grant_hold.sv
// Registers a pick and holds it until the transfer releases it.
module dca_grant_hold
  import dca_pkg::*;
#(
  parameter int unsigned NUM_CH = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] pick_oh,
  input  logic              ext_req,
  input  logic              done,
  output logic [NUM_CH-1:0] grant,
  output logic              ext_grant
);
  arb_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      grant     <= '0;
      ext_grant <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (|pick_oh) begin
            grant <= pick_oh;
            state <= ST_HOLD;
          end else if (ext_req) begin
            ext_grant <= 1'b1;
            state     <= ST_HOLD;
          end
        end
        default: begin
          if (done) begin
            grant     <= '0;
            ext_grant <= 1'b0;
            state     <= ST_IDLE;
          end
        end
      endcase
    end
  end

  // R5: held grant only changes on done
  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && !done) |=> ($stable(grant) && $stable(ext_grant)));

  // R6: done in hold returns to idle with nothing granted
  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && done) |=> (state == ST_IDLE && grant == '0 && !ext_grant));
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter #(
  parameter int unsigned NUM_CH = 7,
  parameter int unsigned LVL_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       req,
  input  logic [NUM_CH-1:0]       ch_en,
  input  logic [NUM_CH*LVL_W-1:0] lvl,
  input  logic                    ext_req,
  input  logic                    done,
  output logic [NUM_CH-1:0]       grant,
  output logic                    ext_grant
);
  logic [NUM_CH-1:0] eligible;
  logic [NUM_CH-1:0] top_mask;
  logic [NUM_CH-1:0] pick_oh;
  logic              busy;

  assign eligible = req & ch_en;
  assign busy     = (|grant) || ext_grant;

  dca_level_sort #(.NUM_CH(NUM_CH), .LVL_W(LVL_W)) u_sort (
    .eligible (eligible),
    .lvl_flat (lvl),
    .top_mask (top_mask)
  );

  dca_first_pick #(.N(NUM_CH)) u_pick (
    .vec    (top_mask),
    .onehot (pick_oh)
  );

  dca_grant_hold #(.NUM_CH(NUM_CH)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .pick_oh   (pick_oh),
    .ext_req   (ext_req),
    .done      (done),
    .grant     (grant),
    .ext_grant (ext_grant)
  );

  // R1: never two grants
  assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ext_grant, grant}));

  // R7: a fresh grant lands only on a requesting, enabled channel
  assert_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ((grant & ~$past(eligible)) == '0));

  // R4: second controller loses to any local contender
  assert_ext_rank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (|eligible)) |=> !ext_grant);

  // R9: done with nothing to grant leaves outputs idle
  assert_idle_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && done && !ext_req && eligible == '0) |=> !busy);
endmodule

// File: tb/sim_dma_chan_arbiter.sv
module sim_dma_chan_arbiter;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  req, ch_en;
  logic [13:0] lvl;
  logic        ext_req, done;
  logic [6:0]  grant;
  logic        ext_grant;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;

  always #(CLK_PER/2) clk = ~clk;

  dma_chan_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .ch_en(ch_en), .lvl(lvl),
    .ext_req(ext_req), .done(done), .grant(grant), .ext_grant(ext_grant)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fails++;
      $display("FAIL watchdog: act=%0d expected<=%0d cycles", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Expected {ext_grant, grant} from the requirements
  function automatic logic [7:0] model(input logic [6:0] rq, input logic [6:0] en,
                                       input logic [13:0] lv, input logic ex);
    logic [6:0] el;
    el = rq & en;
    for (int l = 3; l >= 0; l--)
      for (int i = 0; i < 7; i++)
        if (el[i] && int'(lv[i*2 +: 2]) == l) return 8'(1 << i);
    return ex ? 8'h80 : 8'h00;
  endfunction

  function automatic logic [1:0] lvl_of(input int cfg, input int i);
    return 2'((cfg * 3 + i * (cfg + 1) + i * i) % 4);
  endfunction

  initial begin
    logic [7:0] exp;
    rst_n = 1'b0; req = '0; ch_en = '0; lvl = '0; ext_req = 1'b0; done = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 in reset", {ext_grant, grant}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after reset", {ext_grant, grant}, 8'h00);

    // Sweep: R1 R2 R3 R4 R7 R11 R6 R9
    for (int cfg = 0; cfg < 8; cfg++) begin
      for (int r = 0; r < 128; r++) begin
        req     = 7'(r);
        ch_en   = (cfg % 2 == 0) ? 7'h7F : 7'(8'h6D >> (cfg / 2));
        ext_req = ((r * 5 + cfg) % 3 == 0);
        for (int i = 0; i < 7; i++) lvl[i*2 +: 2] = lvl_of(cfg, i);
        exp = model(req, ch_en, lvl, ext_req);
        #1;
        check("R11 no combinational grant", {ext_grant, grant}, 8'h00);
        @(negedge clk);
        check("R2_R3_R4_R7 sweep pick", {ext_grant, grant}, exp);
        check("R1 onehot", 8'($countones({ext_grant, grant}) <= 1), 8'h01);
        done = 1'b1;
        @(negedge clk);
        check(exp == 0 ? "R9 idle done" : "R6 release", {ext_grant, grant}, 8'h00);
        done = 1'b0;
      end
    end

    // R3 explicit tie
    ch_en = 7'h7F; ext_req = 1'b1; lvl = {7{2'd1}}; req = 7'b1101000;
    @(negedge clk);
    check("R3 tie lowest index", {ext_grant, grant}, 8'h08);
    done = 1'b1; @(negedge clk); done = 1'b0;

    // R2 explicit: channel 6 at level 3 beats channel 0 at level 2
    lvl = '0; lvl[13:12] = 2'd3; lvl[1:0] = 2'd2; req = 7'b1000001;
    @(negedge clk);
    check("R2 level beats index", {ext_grant, grant}, 8'h40);
    done = 1'b1; @(negedge clk); done = 1'b0;

    // R5: no pre-emption
    lvl = '0; ext_req = 1'b0; req = 7'b0010000;
    @(negedge clk);
    check("R5 initial grant", {ext_grant, grant}, 8'h10);
    req = 7'h7F; lvl = {7{2'd3}}; ext_req = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R5 held", {ext_grant, grant}, 8'h10);
    end
    req = '0;
    @(negedge clk);
    check("R5 held after req drop", {ext_grant, grant}, 8'h10);
    done = 1'b1; @(negedge clk); done = 1'b0;
    check("R6 release", {ext_grant, grant}, 8'h00);
    ext_req = 1'b0;

    // R8: level change while held
    lvl = '0; lvl[5:4] = 2'd3; lvl[11:10] = 2'd0; req = 7'b0100100;
    @(negedge clk);
    check("R8 first pick ch2", {ext_grant, grant}, 8'h04);
    lvl[5:4] = 2'd0; lvl[11:10] = 2'd3;
    @(negedge clk);
    check("R8 hold ignores level change", {ext_grant, grant}, 8'h04);
    done = 1'b1; @(negedge clk); done = 1'b0;
    @(negedge clk);
    check("R8 new level used next", {ext_grant, grant}, 8'h20);
    done = 1'b1; @(negedge clk); done = 1'b0;

    // R7: enabled-off channel with high level is skipped
    lvl = '0; lvl[1:0] = 2'd3; ch_en = 7'h7E; req = 7'b0000011;
    @(negedge clk);
    check("R7 masked channel skipped", {ext_grant, grant}, 8'h02);
    done = 1'b1; @(negedge clk); done = 1'b0;

    // R4: second controller only when local side is quiet
    req = 7'b0000001; ext_req = 1'b1;
    @(negedge clk);
    check("R4 masked-only local lets ext win", {ext_grant, grant}, 8'h80);
    done = 1'b1; @(negedge clk); done = 1'b0;

    // R9: done pulses with nothing held
    req = '0; ext_req = 1'b0; done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    check("R9 done while idle", {ext_grant, grant}, 8'h00);
    req = 7'b0001000;
    @(negedge clk);
    check("R9 arbitration after idle done", {ext_grant, grant}, 8'h08);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule